// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds a set of 32-bit event counters and one 32-bit cycle counter for a processor core. Each event counter carries a programmable 8-bit event type and two privilege filter flags. An external decoder reads the types and feeds each counter a per-cycle increment amount. The block also keeps the global control bits, the enable and interrupt-enable masks, a sticky overflow status and a level interrupt.

Software reaches the block through a single write port. A write carries a selector, an index and a 32-bit data word, and it takes effect at the clock edge on which `wr_en` is high. Counters, masks and status are read directly from the output ports. A counter advances only while the global enable and its own enable bit are both set and its filter flags allow the current privilege level. Type 0x00 marks a software-increment counter. Every other code takes its amount from the core, for example 0x08 for retired instructions and 0x11 for cycles.

Top module: `perf_cnt_bank`

## Requirements
- R1: While the global enable (control bit 0) is 0, no counter changes except through a load or a reset write. Software-increment writes made during that time are dropped, not kept for later.
- R2: A control write with bit 1 set zeroes every event counter, and one with bit 2 set zeroes only the cycle counter. Either reset takes priority over an increment in the same cycle.
- R3: While control bit 3 is 1, the cycle counter advances once per 64 enabled cycles. A write with bit 2 restarts that 64-cycle phase. Once bit 3 is cleared, the counter advances once per enabled cycle.
- R4: Mask bit 31 belongs to the cycle counter and bit n to event counter n. Bits of counters that are not implemented always read 0.
- R5: Selector 1 sets and selector 2 clears bits of the enable mask. Selector 3 sets and selector 4 clears bits of the interrupt-enable mask. Only data bits that are 1 have an effect.
- R6: A write with selector 6 adds 1 to counter n for each data bit n that is set, but only if counter n has type 0x00, its enable bit is set and the global enable is set. The write has no effect on counters of any other type.
- R7: A configure write (selector 8) sets the counter's type from data[7:0], which reads back unchanged. Any nonzero type, even one no decoder implements, adds its event amount input each enabled cycle.
- R8: A counter wraps modulo 2^32, and a wrap sets its bit in the overflow status. For example, 5 plus 0xFFFFFFFF gives 4.
- R9: `irq_o` is 1 while some counter has both its overflow bit and its interrupt-enable bit set. A write with selector 5 clears the status bits whose data bits are 1.
- R10: Configure data bit 8 stops a counter from counting while `priv_i` is 0, and bit 9 stops it while `priv_i` is 1. A counter that is stopped this way neither advances nor overflows.
- R11: A write with selector 7 loads data into counter `wr_idx`, and index 31 selects the cycle counter. Selector 0 writes the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | write strobe |
| wr_sel | input | 4 | write selector (0 control … 8 configure) |
| wr_idx | input | 5 | counter index for load and configure |
| wr_data | input | 32 | write data |
| priv_i | input | 1 | 1 = privileged level |
| evt_amt_i | input | N_EVT*32 | per-counter event amount this cycle |
| cnt_o | output | N_EVT*32 | event counter values |
| cyc_o | output | 32 | cycle counter value |
| evt_type_o | output | N_EVT*8 | event type of each counter |
| ctrl_o | output | 4 | control readback (reset bits read 0) |
| en_o | output | 32 | enable mask |
| ie_o | output | 32 | interrupt-enable mask |
| ovf_o | output | 32 | overflow status |
| irq_o | output | 1 | overflow interrupt level |

## Verification
The assertions assume that `wr_idx` stays below N_EVT or equals 31, and that the event amounts go only to counters whose types call for them. The bench holds every event amount at zero across configure and load writes, so that the value that lands in a counter is fixed by the write alone. Event amounts change only on falling edges and are held for a known number of rising edges. Each expected count is therefore a product that the bench works out without reference to the design.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  localparam int CW      = 32;
  localparam int TW      = 8;
  localparam int MW      = 32;
  localparam int IDXW    = 5;
  localparam int CYC_BIT = 31;
  localparam int DIV_LOG = 6;

  localparam logic [3:0] SEL_CTRL   = 4'd0;
  localparam logic [3:0] SEL_EN_SET = 4'd1;
  localparam logic [3:0] SEL_EN_CLR = 4'd2;
  localparam logic [3:0] SEL_IE_SET = 4'd3;
  localparam logic [3:0] SEL_IE_CLR = 4'd4;
  localparam logic [3:0] SEL_OVF_CL = 4'd5;
  localparam logic [3:0] SEL_SWINC  = 4'd6;
  localparam logic [3:0] SEL_LOAD   = 4'd7;
  localparam logic [3:0] SEL_CFG    = 4'd8;

  localparam logic [TW-1:0] EV_SOFT = 8'h00;

  // 33-bit accumulate: carry bit is the wrap indication
  function automatic logic [CW:0] acc_step(input logic [CW-1:0] cur,
                                           input logic [CW-1:0] amt);
    return {1'b0, cur} + {1'b0, amt};
  endfunction

  function automatic logic level_ok(input logic priv, input logic no_user,
                                    input logic no_priv);
    return priv ? !no_priv : !no_user;
  endfunction

  function automatic logic [MW-1:0] impl_mask(input int n_evt);
    return (MW'(1) << CYC_BIT) | ((MW'(1) << n_evt) - MW'(1));
  endfunction
endpackage

// File: rtl/perf_evt_slot.sv
module perf_evt_slot
  import perf_cnt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [9:0]    cfg_data,
  input  logic          load_we,
  input  logic [CW-1:0] load_val,
  input  logic          zero,
  input  logic          run,
  input  logic          sw_hit,
  input  logic          priv,
  input  logic [CW-1:0] amt,
  output logic [CW-1:0] cnt,
  output logic [TW-1:0] ev_type,
  output logic          wrap
);
  logic [TW-1:0] type_q;
  logic          nou_q, nop_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] inc;
  logic [CW:0]   sum;
  logic          live;

  always_comb begin
    inc  = (type_q == EV_SOFT) ? CW'(sw_hit) : amt;
    live = run && level_ok(priv, nou_q, nop_q) && (inc != '0);
    sum  = acc_step(cnt_q, inc);
  end

  assign wrap    = live && sum[CW] && !zero && !load_we;
  assign cnt     = cnt_q;
  assign ev_type = type_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      nou_q  <= 1'b0;
      nop_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (cfg_we) {nop_q, nou_q, type_q} <= cfg_data;
      if (zero)         cnt_q <= '0;
      else if (load_we) cnt_q <= load_val;
      else if (live)    cnt_q <= sum[CW-1:0];
    end
  end
endmodule

// File: rtl/perf_cyc_cnt.sv
module perf_cyc_cnt
  import perf_cnt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zero,
  input  logic          load_we,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  input  logic          div,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic [DIV_LOG-1:0] presc_q;
  logic [CW-1:0]      cnt_q;
  logic [CW:0]        sum;
  logic               tick;

  assign tick = run && (!div || presc_q == '1);
  assign sum  = acc_step(cnt_q, CW'(1));
  assign wrap = tick && sum[CW] && !zero && !load_we;
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (zero)             presc_q <= '0;
      else if (run && div)  presc_q <= presc_q + 1'b1;
      if (zero)         cnt_q <= '0;
      else if (load_we) cnt_q <= load_val;
      else if (tick)    cnt_q <= sum[CW-1:0];
    end
  end
endmodule

// File: rtl/perf_masks.sv
module perf_masks
  import perf_cnt_pkg::*;
#(
  parameter int N_EVT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          ie_set,
  input  logic          ie_clr,
  input  logic          ovf_clr,
  input  logic [MW-1:0] data,
  input  logic [MW-1:0] ovf_evt,
  output logic [MW-1:0] en_q,
  output logic [MW-1:0] ie_q,
  output logic [MW-1:0] ovf_q
);
  localparam logic [MW-1:0] IMPL = impl_mask(N_EVT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ie_q  <= '0;
      ovf_q <= '0;
    end else begin
      en_q  <= (en_q | (en_set ? data : '0)) & ~(en_clr ? data : '0) & IMPL;
      ie_q  <= (ie_q | (ie_set ? data : '0)) & ~(ie_clr ? data : '0) & IMPL;
      // a new wrap wins over a clear in the same cycle
      ovf_q <= ((ovf_q & ~(ovf_clr ? data : '0)) | ovf_evt) & IMPL;
    end
  end
endmodule

// File: rtl/perf_cnt_bank.sv
module perf_cnt_bank
  import perf_cnt_pkg::*;
#(
  parameter int N_EVT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_sel,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [31:0]        wr_data,
  input  logic               priv_i,
  input  logic [N_EVT*CW-1:0] evt_amt_i,
  output logic [N_EVT*CW-1:0] cnt_o,
  output logic [CW-1:0]      cyc_o,
  output logic [N_EVT*TW-1:0] evt_type_o,
  output logic [3:0]         ctrl_o,
  output logic [MW-1:0]      en_o,
  output logic [MW-1:0]      ie_o,
  output logic [MW-1:0]      ovf_o,
  output logic               irq_o
);
  // named internal events for the checker
  logic            glob_en, div64;
  logic            ctrl_wr, sw_wr, load_wr, cfg_wr;
  logic            zero_evt, zero_cyc;
  logic [MW-1:0]   ovf_evt;
  logic [MW-1:0]   en_q, ie_q, ovf_q;

  assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
  assign sw_wr    = wr_en && (wr_sel == SEL_SWINC);
  assign load_wr  = wr_en && (wr_sel == SEL_LOAD);
  assign cfg_wr   = wr_en && (wr_sel == SEL_CFG);
  assign zero_evt = ctrl_wr && wr_data[1];
  assign zero_cyc = ctrl_wr && wr_data[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      div64   <= 1'b0;
    end else if (ctrl_wr) begin
      glob_en <= wr_data[0];
      div64   <= wr_data[3];
    end
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_slot
    perf_evt_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_wr && (wr_idx == IDXW'(g))),
      .cfg_data (wr_data[9:0]),
      .load_we  (load_wr && (wr_idx == IDXW'(g))),
      .load_val (wr_data),
      .zero     (zero_evt),
      .run      (glob_en && en_q[g]),
      .sw_hit   (sw_wr && wr_data[g]),
      .priv     (priv_i),
      .amt      (evt_amt_i[g*CW +: CW]),
      .cnt      (cnt_o[g*CW +: CW]),
      .ev_type  (evt_type_o[g*TW +: TW]),
      .wrap     (ovf_evt[g])
    );
  end

  for (genvar u = N_EVT; u < CYC_BIT; u++) begin : g_unused
    assign ovf_evt[u] = 1'b0;
  end

  perf_cyc_cnt u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .zero     (zero_cyc),
    .load_we  (load_wr && (wr_idx == IDXW'(CYC_BIT))),
    .load_val (wr_data),
    .run      (glob_en && en_q[CYC_BIT]),
    .div      (div64),
    .cnt      (cyc_o),
    .wrap     (ovf_evt[CYC_BIT])
  );

  perf_masks #(.N_EVT(N_EVT)) u_masks (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_set  (wr_en && (wr_sel == SEL_EN_SET)),
    .en_clr  (wr_en && (wr_sel == SEL_EN_CLR)),
    .ie_set  (wr_en && (wr_sel == SEL_IE_SET)),
    .ie_clr  (wr_en && (wr_sel == SEL_IE_CLR)),
    .ovf_clr (wr_en && (wr_sel == SEL_OVF_CL)),
    .data    (wr_data),
    .ovf_evt (ovf_evt),
    .en_q    (en_q),
    .ie_q    (ie_q),
    .ovf_q   (ovf_q)
  );

  assign en_o   = en_q;
  assign ie_o   = ie_q;
  assign ovf_o  = ovf_q;
  assign ctrl_o = {div64, 2'b00, glob_en};
  assign irq_o  = |(ovf_q & ie_q);
endmodule

// File: rtl/perf_cnt_bank_chk.sv
module perf_cnt_bank_chk
  import perf_cnt_pkg::*;
#(
  parameter int N_EVT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [3:0]         wr_sel,
  input logic [31:0]        wr_data,
  input logic               glob_en,
  input logic [MW-1:0]      ovf_evt,
  input logic [N_EVT*CW-1:0] cnt_o,
  input logic [CW-1:0]      cyc_o,
  input logic [MW-1:0]      en_o,
  input logic [MW-1:0]      ovf_o,
  input logic               irq_o
);
  localparam logic [MW-1:0] IMPL = impl_mask(N_EVT);

  a_r1_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !wr_en) |=> ($stable(cnt_o) && $stable(cyc_o)))
    else $error("R1 counter moved while disabled");

  a_r2_evt_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTRL && wr_data[1]) |=> (cnt_o == '0))
    else $error("R2 event counters not zeroed");

  a_r5_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_EN_SET) |=>
      ((en_o & $past(wr_data & IMPL)) == $past(wr_data & IMPL)))
    else $error("R5 enable set lost");

  a_r8_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ovf_o & ~$past(ovf_o))) |-> $past(|ovf_evt))
    else $error("R8 status bit set without a wrap");

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(|ovf_evt)) |=> $stable(irq_o))
    else $error("R9 interrupt changed without cause");
endmodule

bind perf_cnt_bank perf_cnt_bank_chk #(.N_EVT(N_EVT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .glob_en (glob_en),
  .ovf_evt (ovf_evt),
  .cnt_o   (cnt_o),
  .cyc_o   (cyc_o),
  .en_o    (en_o),
  .ovf_o   (ovf_o),
  .irq_o   (irq_o)
);

// File: tb/perf_cnt_bank_tb.sv
module perf_cnt_bank_tb;
  localparam int N = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_sel = '0;
  logic [4:0]    wr_idx = '0;
  logic [31:0]   wr_data = '0;
  logic          priv = 1'b1;
  logic [N*32-1:0] evt_amt = '0;
  logic [N*32-1:0] cnt_o;
  logic [31:0]   cyc_o;
  logic [N*8-1:0] evt_type_o;
  logic [3:0]    ctrl_o;
  logic [31:0]   en_o, ie_o, ovf_o;
  logic          irq_o;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  perf_cnt_bank #(.N_EVT(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data), .priv_i(priv),
    .evt_amt_i(evt_amt), .cnt_o(cnt_o), .cyc_o(cyc_o),
    .evt_type_o(evt_type_o), .ctrl_o(ctrl_o), .en_o(en_o),
    .ie_o(ie_o), .ovf_o(ovf_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [1:0]  flt;   // [1] stop privileged, [0] stop unprivileged
    logic        pr;
    logic [31:0] amt;
    logic [7:0]  n;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{2'b00, 1'b1, 32'd3,       8'd4, 32'd12},
    '{2'b01, 1'b1, 32'd7,       8'd2, 32'd14},
    '{2'b01, 1'b0, 32'd7,       8'd2, 32'd0},
    '{2'b10, 1'b1, 32'd9,       8'd3, 32'd0},
    '{2'b10, 1'b0, 32'd9,       8'd3, 32'd27},
    '{2'b11, 1'b0, 32'd1,       8'd5, 32'd0},
    '{2'b00, 1'b0, 32'h10000,   8'd2, 32'h20000}
  };

  function automatic logic [31:0] cnt(input int k);
    return cnt_o[k*32 +: 32];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [4:0] i, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_idx = i; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R4 reset en", en_o, 32'h0);
    chk("R9 reset irq", {31'b0, irq_o}, 32'h0);
    chk("R8 reset ovf", ovf_o, 32'h0);
    chk("R1 reset cnt0", cnt(0), 32'h0);
    chk("R11 reset ctrl", {28'b0, ctrl_o}, 32'h0);

    wr(4'd0, 5'd0, 32'h1);
    chk("R11 ctrl readback", {28'b0, ctrl_o}, 32'h1);
    wr(4'd1, 5'd0, 32'hFFFF_FFFF);
    chk("R4 unimplemented bits read 0", en_o, 32'h8000_000F);
    wr(4'd2, 5'd0, 32'h4);
    chk("R5 clear one bit", en_o, 32'h8000_000B);
    wr(4'd1, 5'd0, 32'h0);
    chk("R5 zero write no effect", en_o, 32'h8000_000B);

    // privilege filter and event amount table on counter 0
    for (int v = 0; v < 7; v++) begin
      wr(4'd8, 5'd0, {22'b0, VEC[v].flt, 8'h08});
      wr(4'd7, 5'd0, 32'h0);
      priv = VEC[v].pr;
      evt_amt[31:0] = VEC[v].amt;
      repeat (int'(VEC[v].n)) @(negedge clk);
      evt_amt[31:0] = '0;
      chk($sformatf("R10/R7 vector %0d", v), cnt(0), VEC[v].exp);
    end
    priv = 1'b1;

    // R1: global off drops everything
    wr(4'd0, 5'd0, 32'h0);
    wr(4'd8, 5'd1, 32'h0);
    wr(4'd8, 5'd2, 32'h0);
    wr(4'd6, 5'd0, 32'h2);
    evt_amt[31:0] = 32'd5;
    repeat (3) @(negedge clk);
    evt_amt[31:0] = '0;
    chk("R1 swinc dropped", cnt(1), 32'h0);
    chk("R1 events ignored", cnt(0), 32'h20000);
    wr(4'd0, 5'd0, 32'h1);
    chk("R1 dropped swinc not deferred", cnt(1), 32'h0);

    // R6 software increment gating
    wr(4'd6, 5'd0, 32'h7);
    chk("R6 type0 enabled counts", cnt(1), 32'h1);
    chk("R6 disabled counter ignores", cnt(2), 32'h0);
    chk("R6 nonzero type ignores", cnt(0), 32'h20000);

    // R2 resets
    evt_amt[31:0] = 32'd5;
    wr(4'd0, 5'd0, 32'h3);
    chk("R2 reset beats increment", cnt(0), 32'h0);
    chk("R2 all event counters zero", cnt(1), 32'h0);
    chk("R2 cycle counter kept", {31'b0, cyc_o != 0}, 32'h1);
    @(negedge clk);
    evt_amt[31:0] = '0;
    chk("R2 counting resumes", cnt(0), 32'd5);
    wr(4'd0, 5'd0, 32'h5);
    chk("R2 cycle counter zeroed", cyc_o, 32'h0);
    chk("R2 event counter untouched", cnt(0), 32'd5);

    // R3 divide by 64
    wr(4'd0, 5'd0, 32'hD);
    repeat (128) @(negedge clk);
    chk("R3 div64 count", cyc_o, 32'd2);
    wr(4'd0, 5'd0, 32'h1);
    repeat (10) @(negedge clk);
    chk("R3 per-cycle restored", cyc_o, 32'd12);

    // R7/R8/R9 wrap and interrupt
    wr(4'd8, 5'd3, 32'hAB);
    chk("R7 type readback", {24'b0, evt_type_o[31:24]}, 32'hAB);
    wr(4'd7, 5'd3, 32'd5);
    chk("R11 load value", cnt(3), 32'd5);
    wr(4'd3, 5'd0, 32'h8);
    chk("R5 ie set", ie_o, 32'h8);
    evt_amt[127:96] = 32'hFFFF_FFFF;
    @(negedge clk);
    evt_amt[127:96] = '0;
    chk("R8 wrap value", cnt(3), 32'd4);
    chk("R8 status set", ovf_o, 32'h8);
    chk("R9 irq high", {31'b0, irq_o}, 32'h1);
    wr(4'd5, 5'd0, 32'h8);
    chk("R9 status cleared", ovf_o, 32'h0);
    chk("R9 irq low", {31'b0, irq_o}, 32'h0);
    wr(4'd4, 5'd0, 32'h8);
    wr(4'd7, 5'd3, 32'hFFFF_FFFF);
    evt_amt[127:96] = 32'd1;
    @(negedge clk);
    evt_amt[127:96] = '0;
    chk("R8 wrap to zero", cnt(3), 32'h0);
    chk("R9 irq masked", {31'b0, irq_o}, 32'h0);

    // cycle counter wrap
    wr(4'd7, 5'd31, 32'hFFFF_FFFE);
    repeat (2) @(negedge clk);
    chk("R8 cycle wrap value", cyc_o, 32'h0);
    chk("R8 cycle status bit 31", ovf_o, 32'h8000_0008);

    finish_run();
  end
endmodule